// File: doc/BRIEF.md
# Polyphase Position Accumulator

This block tracks where each output sample of a resampling filter falls on the input grid. One instance serves one direction and one colour component. For a horizontal pass the advance strobe means one output pixel; for a vertical pass it means one output line. A shrink factor is the ratio of input pitch to output pitch, held as an unsigned fixed-point number with 4 integer and 20 fraction bits. Values above 1.0 shrink the image and values below 1.0 enlarge it. For example, 0x180000 (1.5) maps 1080 lines to 720, and 0x0A0000 (0.625) maps 640 pixels to 1024. The legal range runs from 0x015555 (about 1/12) up to 0xC00000 (12.0).

A start pulse loads a signed 21-bit start offset into the position register. The offset is a two's-complement value with 20 fraction bits, so it spans -1.0 up to just under +1.0. The same pulse also captures the factor, the phase count and the rectangle length. For every output the block presents three things: a coefficient phase index, the number of input samples the filter window must move after this output, and a flag that marks the final output of the rectangle.

While the position is still negative, the block holds the input position at sample zero. This replicates the first sample at the leading edge. The phase index is floor(fraction × phases), which lets counts that are not a power of two divide the unit interval evenly. The filter arithmetic lives elsewhere.

The controller has three states:
- **ST_IDLE**: no rectangle is active.
- **ST_EDGE**: the position is below zero and is being clamped.
- **ST_TRACK**: the position is non-negative and only its fraction is kept.

The transitions are:
- **start-negative**: any state goes to ST_EDGE on a start pulse whose offset has its sign bit set.
- **start-positive**: any state goes to ST_TRACK on a start pulse whose offset is non-negative.
- **cross**: ST_EDGE goes to ST_TRACK on an advance whose sum becomes non-negative.
- **hold**: ST_EDGE stays in ST_EDGE on an advance whose sum is still negative.
- **step**: ST_TRACK stays in ST_TRACK on an advance that is not the last one.
- **finish**: ST_EDGE or ST_TRACK goes to ST_IDLE on an advance taken at the last output.

Top module: `poly_pos_accum`

## Requirements
- R1: While reset is high, and after it until the first start pulse, `active`, `rect_last`, `phase_idx` and `in_step` are all 0.
- R2: A start pulse captures `shrink`, `num_phases` and `out_len` and loads the position from `start_frac` (bit 20 is the sign, 20 fraction bits). In the next cycle `active` is 1 and output index 0 is presented. Changes on those inputs while a rectangle runs have no effect on its outputs.
- R3: In ST_TRACK, `phase_idx` equals floor(frac × N), where frac is the 20-bit position fraction and N is the captured phase count. N may be any value from 2 to 16, or 32 or 64. Example: a factor of 0x140000 with N=4 from a zero start gives phases 0, 1, 2, 3 over four outputs.
- R4: On each accepted advance, the factor is added to the position. `in_step` shows the integer part of that sum for the current output, and only the fraction is kept. With a factor of 12.0, `in_step` is 12.
- R5: While the position is negative, `phase_idx` is 0. `in_step` is 0 while position plus factor stays negative. On the advance where the sum first becomes non-negative, `in_step` is its integer part and the kept fraction is the sum's fraction.
- R6: `rect_last` is 1 exactly on output index `out_len`−1 and only while `active`. An advance taken there returns the block to ST_IDLE. An `out_len` of 1 flags the first output.
- R7: A start pulse during an active rectangle restarts it from index 0 with the new offset, and it takes priority over a simultaneous advance.
- R8: An advance while no rectangle is active has no effect: `active` and all outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rect_start | input | 1 | Start-of-rectangle pulse; loads offset and captures controls |
| adv | input | 1 | Advance to the next output sample or line |
| shrink | input | 24 | Input-to-output pitch ratio, unsigned 4.20 |
| start_frac | input | 21 | Signed start offset, 20 fraction bits |
| num_phases | input | 7 | Number of coefficient phases (2–16, 32, 64) |
| out_len | input | 11 | Outputs in the rectangle (at least 1) |
| phase_idx | output | 7 | Coefficient phase for the current output |
| in_step | output | 4 | Input samples to move after the current output |
| rect_last | output | 1 | Current output is the final one |
| active | output | 1 | A rectangle is in progress |

## Verification
The bench targets phase counts of 3, 5, 7 and 9, where a design that took the top bits of the fraction instead of scaling by the count would return wrong or out-of-range phases. It drives negative offsets, including -1.0 and an offset that crosses zero partway through an advance. A design that did not clamp there would emit a nonzero phase or a spurious step, or would drop the fraction at the crossing. Both extreme factors are exercised, along with a rectangle of length one. Control inputs are changed mid-rectangle, and a restart is made on top of an advance; a design that failed to capture the controls or to give the start priority would move the end flag or continue the old position.

// File: rtl/scaler_pos_pkg.sv
package scaler_pos_pkg;
    localparam int FRAC_W  = 20;
    localparam int INT_W   = 4;
    localparam int NPH_W   = 7;
    localparam int LEN_W   = 11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EDGE  = 2'd1,
        ST_TRACK = 2'd2
    } pos_state_e;
endpackage

// File: rtl/pos_phase_map.sv
module pos_phase_map #(
    parameter int FRAC_BITS = 20,
    parameter int NPH_BITS  = 7
) (
    input  logic [FRAC_BITS-1:0] frac,
    input  logic [NPH_BITS-1:0]  nph,
    output logic [NPH_BITS-1:0]  phase
);
    localparam int PROD_BITS = FRAC_BITS + NPH_BITS;

    logic [PROD_BITS-1:0] prod;

    // fraction < 1, so the scaled value stays below nph and fits in NPH_BITS
    always_comb begin
        prod  = PROD_BITS'(frac) * PROD_BITS'(nph);
        phase = prod[PROD_BITS-1:FRAC_BITS];
    end
endmodule

// File: rtl/pos_step_unit.sv
module pos_step_unit #(
    parameter int FRAC_BITS = 20,
    parameter int INT_BITS  = 4
) (
    input  logic [INT_BITS+FRAC_BITS:0]   acc,
    input  logic [INT_BITS+FRAC_BITS-1:0] sf,
    output logic                          nonneg,
    output logic [INT_BITS-1:0]           step,
    output logic [INT_BITS+FRAC_BITS:0]   acc_next
);
    localparam int ACC_BITS = INT_BITS + FRAC_BITS + 1;

    logic [ACC_BITS-1:0] sum;

    always_comb begin
        sum    = acc + {1'b0, sf};
        nonneg = ~sum[ACC_BITS-1];
        if (nonneg) begin
            step     = sum[ACC_BITS-2:FRAC_BITS];
            acc_next = {{(INT_BITS+1){1'b0}}, sum[FRAC_BITS-1:0]};
        end else begin
            step     = '0;
            acc_next = sum;
        end
    end
endmodule

// File: rtl/poly_pos_accum.sv
module poly_pos_accum
    import scaler_pos_pkg::*;
#(
    parameter int FRAC_BITS = FRAC_W,
    parameter int INT_BITS  = INT_W,
    parameter int NPH_BITS  = NPH_W,
    parameter int LEN_BITS  = LEN_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rect_start,
    input  logic                          adv,
    input  logic [INT_BITS+FRAC_BITS-1:0] shrink,
    input  logic [FRAC_BITS:0]            start_frac,
    input  logic [NPH_BITS-1:0]           num_phases,
    input  logic [LEN_BITS-1:0]           out_len,
    output logic [NPH_BITS-1:0]           phase_idx,
    output logic [INT_BITS-1:0]           in_step,
    output logic                          rect_last,
    output logic                          active
);
    localparam int SF_BITS  = INT_BITS + FRAC_BITS;
    localparam int ST_BITS  = FRAC_BITS + 1;
    localparam int ACC_BITS = SF_BITS + 1;
    localparam logic [LEN_BITS-1:0] LEN_ONE = LEN_BITS'(1);

    pos_state_e            st_q, st_d;
    logic [ACC_BITS-1:0]   acc_q;
    logic [SF_BITS-1:0]    sf_q;
    logic [NPH_BITS-1:0]   nph_q;
    logic [LEN_BITS-1:0]   len_q, idx_q;

    logic                  sum_nonneg;
    logic [INT_BITS-1:0]   step_raw;
    logic [ACC_BITS-1:0]   acc_nx;
    logic [NPH_BITS-1:0]   phase_raw;
    logic [ACC_BITS-1:0]   start_ext;
    logic                  at_last;
    logic                  take;

    assign start_ext = {{(ACC_BITS-ST_BITS){start_frac[ST_BITS-1]}}, start_frac};
    assign at_last   = (idx_q == (len_q - LEN_ONE));
    assign take      = adv && !rect_start && (st_q != ST_IDLE);

    pos_step_unit #(.FRAC_BITS(FRAC_BITS), .INT_BITS(INT_BITS)) u_step (
        .acc      (acc_q),
        .sf       (sf_q),
        .nonneg   (sum_nonneg),
        .step     (step_raw),
        .acc_next (acc_nx)
    );

    pos_phase_map #(.FRAC_BITS(FRAC_BITS), .NPH_BITS(NPH_BITS)) u_phase (
        .frac  (acc_q[FRAC_BITS-1:0]),
        .nph   (nph_q),
        .phase (phase_raw)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (rect_start) begin
            st_d = start_frac[ST_BITS-1] ? ST_EDGE : ST_TRACK;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_EDGE: begin
                    if (adv) begin
                        if (at_last)         st_d = ST_IDLE;
                        else if (sum_nonneg) st_d = ST_TRACK;
                        else                 st_d = ST_EDGE;
                    end
                end
                ST_TRACK: begin
                    if (adv && at_last) st_d = ST_IDLE;
                end
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // position, index and captured controls
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            idx_q <= '0;
            sf_q  <= '0;
            nph_q <= '0;
            len_q <= '0;
        end else if (rect_start) begin
            acc_q <= start_ext;
            idx_q <= '0;
            sf_q  <= shrink;
            nph_q <= num_phases;
            len_q <= out_len;
        end else if (take) begin
            acc_q <= acc_nx;
            idx_q <= idx_q + LEN_ONE;
        end
    end

    // outputs
    always_comb begin
        phase_idx = '0;
        in_step   = '0;
        rect_last = 1'b0;
        active    = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_EDGE: begin
                active    = 1'b1;
                in_step   = step_raw;
                rect_last = at_last;
            end
            ST_TRACK: begin
                active    = 1'b1;
                phase_idx = phase_raw;
                in_step   = step_raw;
                rect_last = at_last;
            end
            default: ;
        endcase
    end

    // R6
    last_in_rect_chk: assert property (@(posedge clk) disable iff (rst)
        rect_last |-> active);

    // R6
    last_release_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && rect_last && !rect_start) |=> !active);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !rect_start) |=> !active);

    // R7
    start_entry_chk: assert property (@(posedge clk) disable iff (rst)
        rect_start |=> (active && idx_q == '0));

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !rect_start) |=> ($stable(sf_q) && $stable(nph_q) && $stable(len_q)));

    // R4
    track_frac_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TRACK) |-> (acc_q[ACC_BITS-1:FRAC_BITS] == '0));

    // R5
    edge_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EDGE) |-> (acc_q[ACC_BITS-1] && phase_idx == '0));

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TRACK) |-> (phase_idx < nph_q));
endmodule

// File: tb/poly_pos_accum_bench.sv
`timescale 1ns/1ps
module poly_pos_accum_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rect_start = 1'b0;
    logic        adv = 1'b0;
    logic [23:0] shrink = '0;
    logic [20:0] start_frac = '0;
    logic [6:0]  num_phases = 7'd4;
    logic [10:0] out_len = 11'd4;
    logic [6:0]  phase_idx;
    logic [3:0]  in_step;
    logic        rect_last;
    logic        active;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    poly_pos_accum u_poly_pos_accum (
        .clk(clk), .rst(rst), .rect_start(rect_start), .adv(adv),
        .shrink(shrink), .start_frac(start_frac), .num_phases(num_phases),
        .out_len(out_len), .phase_idx(phase_idx), .in_step(in_step),
        .rect_last(rect_last), .active(active)
    );

    typedef struct packed {
        logic [23:0]      sf;
        logic [20:0]      st;
        logic [6:0]       nph;
        logic [3:0][6:0]  ph;
        logic [3:0][3:0]  stp;
        logic [7:0]       req;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{24'h140000, 21'h000000, 7'd4,  {7'd3,7'd2,7'd1,7'd0},     {4'd2,4'd1,4'd1,4'd1},     8'd3},
        '{24'h0A0000, 21'h000000, 7'd5,  {7'd4,7'd1,7'd3,7'd0},     {4'd1,4'd0,4'd1,4'd0},     8'd3},
        '{24'h180000, 21'h080000, 7'd3,  {7'd0,7'd1,7'd0,7'd1},     {4'd1,4'd2,4'd1,4'd2},     8'd4},
        '{24'h0C0000, 21'h180000, 7'd4,  {7'd3,7'd0,7'd1,7'd0},     {4'd1,4'd0,4'd1,4'd0},     8'd5},
        '{24'h040000, 21'h100000, 7'd16, {7'd0,7'd0,7'd0,7'd0},     {4'd0,4'd0,4'd0,4'd0},     8'd5},
        '{24'hC00000, 21'h0C0000, 7'd64, {7'd48,7'd48,7'd48,7'd48}, {4'd12,4'd12,4'd12,4'd12}, 8'd4},
        '{24'h015555, 21'h000000, 7'd7,  {7'd1,7'd1,7'd0,7'd0},     {4'd0,4'd0,4'd0,4'd0},     8'd3}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // launch a rectangle: call at a negedge, returns at the next negedge with output 0 presented
    task automatic launch(input logic [23:0] sf, input logic [20:0] st, input logic [6:0] n, input logic [10:0] len);
        shrink = sf; start_frac = st; num_phases = n; out_len = len;
        rect_start = 1'b1;
        @(negedge clk);
        rect_start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "active in reset", active, 0);
        chk("R1", "last in reset", rect_last, 0);
        chk("R1", "phase in reset", phase_idx, 0);
        chk("R1", "step in reset", in_step, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "active after reset", active, 0);

        // R8: advance while idle
        adv = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", "active on idle advance", active, 0);
        chk("R8", "phase on idle advance", phase_idx, 0);
        chk("R8", "step on idle advance", in_step, 0);
        adv = 1'b0;
        @(negedge clk);

        // vector walk: R3, R4, R5, R6
        for (int v = 0; v < NV; v++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[v].req);
            launch(VEC[v].sf, VEC[v].st, VEC[v].nph, 11'd4);
            for (int k = 0; k < 4; k++) begin
                chk("R2", $sformatf("v%0d k%0d active", v, k), active, 1);
                chk(rq, $sformatf("v%0d k%0d phase", v, k), phase_idx, VEC[v].ph[k]);
                chk("R4", $sformatf("v%0d k%0d step", v, k), in_step, VEC[v].stp[k]);
                chk("R6", $sformatf("v%0d k%0d last", v, k), rect_last, (k == 3));
                adv = 1'b1;
                @(negedge clk);
            end
            chk("R6", $sformatf("v%0d idle after last", v), active, 0);
            adv = 1'b0;
            @(negedge clk);
        end

        // R6: rectangle of one output
        launch(24'h140000, 21'h0, 7'd4, 11'd1);
        chk("R6", "len1 last", rect_last, 1);
        chk("R6", "len1 active", active, 1);
        adv = 1'b1;
        @(negedge clk);
        chk("R6", "len1 idle", active, 0);
        adv = 1'b0;

        // R2: control changes mid-rectangle are ignored
        launch(24'h140000, 21'h0, 7'd4, 11'd4);
        shrink = 24'h0A0000; num_phases = 7'd5; out_len = 11'd2;
        adv = 1'b1;
        @(negedge clk);
        chk("R2", "k1 phase held", phase_idx, 1);
        chk("R2", "k1 step held", in_step, 1);
        chk("R2", "k1 last held", rect_last, 0);
        @(negedge clk);
        chk("R2", "k2 phase held", phase_idx, 2);
        @(negedge clk);
        chk("R2", "k3 last held", rect_last, 1);
        @(negedge clk);
        chk("R2", "idle after held", active, 0);
        adv = 1'b0;

        // R7: restart with simultaneous advance
        launch(24'h140000, 21'h0, 7'd4, 11'd4);
        adv = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7", "before restart phase", phase_idx, 2);
        start_frac = 21'h040000; rect_start = 1'b1;
        @(negedge clk);
        rect_start = 1'b0;
        chk("R7", "restart phase", phase_idx, 1);
        chk("R7", "restart last", rect_last, 0);
        repeat (3) @(negedge clk);
        chk("R7", "restart last at k3", rect_last, 1);
        @(negedge clk);
        chk("R7", "restart ends", active, 0);
        adv = 1'b0;

        // R5 / R4: long run against an arithmetic model, negative offset crossing zero
        begin
            longint a, s;
            longint sfv, nv;
            sfv = 64'h0E38E3; nv = 9;
            a = -64'h04CCCC;
            launch(24'h0E38E3, 21'h1B3334, 7'd9, 11'd40);
            adv = 1'b1;
            for (int k = 0; k < 40; k++) begin
                s = a + sfv;
                chk("R5", $sformatf("run k%0d phase", k), phase_idx,
                    (a < 0) ? 32'd0 : 32'(((a & 64'hFFFFF) * nv) >> 20));
                chk("R4", $sformatf("run k%0d step", k), in_step,
                    (s < 0) ? 32'd0 : 32'(s >> 20));
                chk("R6", $sformatf("run k%0d last", k), rect_last, (k == 39));
                a = (s < 0) ? s : (s & 64'hFFFFF);
                @(negedge clk);
            end
            chk("R6", "run idle", active, 0);
            adv = 1'b0;
        end

        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule